// File: doc/BRIEF.md
# Parallel PRBS Test Pattern Generator

This block produces stimulus words for exercising a wide parallel data link. At its core is a linear-feedback shift register whose length is chosen from four standard sizes. The register is unrolled, so every enabled clock delivers W consecutive bits of the serial pseudo-random sequence as one output word.

A pattern-mode input picks what the words contain. The choices are pure pseudo-random data, a word toggling between all ones and all zeros, or an interleave of the two. The interleave gives a wide bus both random content and full-width transitions.

A reload strobe restarts the pattern from a known seed. The length selection is captured only at reset or reload, so a running stream never changes its polynomial partway through.

Top module: `prbs_pattern_gen`

## Requirements
- R1: While `rst_n` is low at a rising edge, the next cycle shows `data_valid` = 0 and `data_out` = 0. The register is seeded with all ones at the length given by `len_sel`, the toggle level is set to ones and the interleave phase is set to pseudo-random.
- R2: `len_sel` codes 0, 1, 2 and 3 select register lengths N = 7, 15, 23 and 31, with inner taps T = 6, 14, 18 and 28. The serial sequence obeys b(k) = b(k-N) XOR b(k-T), and after seeding the N bits before b(0) are all ones.
- R3: Each pseudo-random word carries the next W serial bits, with bit 0 the earliest. Successive pseudo-random words continue the sequence without a gap. The word appears on `data_out` the cycle after the enabling edge.
- R4: For each length the emitted sequence repeats with period 2^N-1. It never contains N consecutive zeros, so the register never reaches the all-zero state.
- R5: A change of `len_sel` without reset or reload has no effect, and the stream continues at the previously captured length.
- R6: `reload` high at an edge reseeds the register with all ones at the current `len_sel`. It restarts the toggle level at ones and the interleave phase at pseudo-random. It takes priority over `en`, and that cycle gives `data_valid` = 0 with `data_out` held.
- R7: With `en` low and no reload, `data_valid` is 0 the next cycle, `data_out` holds, and the sequence does not advance.
- R8: `mode` codes: 0 = pseudo-random, 1 = toggle, 2 = interleave, 3 = pseudo-random (same as 0).
- R9: In toggle mode every enabled word is all ones or all zeros. The first such word after seeding is all ones, and the words alternate after that.
- R10: In interleave mode the first enabled word after seeding is pseudo-random, and enabled words then alternate between pseudo-random and toggle. The register advances only on pseudo-random words, and the toggle level is shared with toggle mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Produce a word this cycle |
| reload | input | 1 | Reseed register and capture length |
| len_sel | input | 2 | Register length code |
| mode | input | 2 | Pattern mode code |
| data_out | output | W | Output word, bit 0 earliest |
| data_valid | output | 1 | Word on `data_out` is new this cycle |

## Verification
The bench targets the seams between words. It checks that bit 0 of each word follows bit W-1 of the previous pseudo-random word. A design that reversed the bit order or dropped a step at the word boundary would diverge from the serial model at once. Interleave runs with idle cycles mixed in expose a register that wrongly advances on toggle words or whose phase moves while `en` is low. Changing the length without a reload catches a design that picks up `len_sel` live. Full-period runs at the two shorter lengths catch a wrong tap, which would shorten the period or produce a run of N zeros.

// File: rtl/prbs_pkg.sv
// Package: shared encodings and per-length constants for the PRBS generator.
// Assumes the longest register is 31 bits; all lengths fit in STATE_W.
package prbs_pkg;

    localparam int STATE_W = 31;
    localparam int IDX_W   = $clog2(STATE_W);

    typedef enum logic [1:0] {
        LEN_7  = 2'd0,
        LEN_15 = 2'd1,
        LEN_23 = 2'd2,
        LEN_31 = 2'd3
    } prbs_len_e;

    typedef enum logic [1:0] {
        PAT_PRBS     = 2'd0,
        PAT_TOGGLE   = 2'd1,
        PAT_MIX      = 2'd2,
        PAT_PRBS_ALT = 2'd3
    } prbs_mode_e;

    // Index of the oldest stored bit (length minus one).
    function automatic logic [IDX_W-1:0] outer_idx(prbs_len_e l);
        case (l)
            LEN_7:   return IDX_W'(6);
            LEN_15:  return IDX_W'(14);
            LEN_23:  return IDX_W'(22);
            default: return IDX_W'(30);
        endcase
    endfunction

    // Index of the inner feedback tap (tap position minus one).
    function automatic logic [IDX_W-1:0] inner_idx(prbs_len_e l);
        case (l)
            LEN_7:   return IDX_W'(5);
            LEN_15:  return IDX_W'(13);
            LEN_23:  return IDX_W'(17);
            default: return IDX_W'(27);
        endcase
    endfunction

    // Mask of the bits used by a given length; also the all-ones seed.
    function automatic logic [STATE_W-1:0] len_mask(prbs_len_e l);
        case (l)
            LEN_7:   return STATE_W'(32'h0000_007F);
            LEN_15:  return STATE_W'(32'h0000_7FFF);
            LEN_23:  return STATE_W'(32'h007F_FFFF);
            default: return STATE_W'(32'h7FFF_FFFF);
        endcase
    endfunction

endpackage

// File: rtl/prbs_lfsr_unroll.sv
// Module: combinational W-step unroll of the selectable-length shift register.
// Each step forms the new bit as the XOR of the oldest bit and the inner tap,
// emits it as the next output bit (bit 0 first) and shifts it in at bit 0.
// Assumes the incoming state has zeros above the selected length.
module prbs_lfsr_unroll
    import prbs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [STATE_W-1:0] state_i,
    input  prbs_len_e          len_i,
    output logic [STATE_W-1:0] state_o,
    output logic [W-1:0]       bits_o
);

    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;

    // Tap positions for the captured length.
    always_comb begin
        hi_idx = outer_idx(len_i);
        lo_idx = inner_idx(len_i);
    end

    // Unrolled shift: W serial steps in one cycle.
    always_comb begin
        logic [STATE_W-1:0] s;
        logic               fb;
        s = state_i;
        bits_o = '0;
        for (int i = 0; i < W; i++) begin
            fb        = s[hi_idx] ^ s[lo_idx];
            bits_o[i] = fb;
            s         = {s[STATE_W-2:0], fb};
        end
        state_o = s & len_mask(len_i);
    end

endmodule

// File: rtl/prbs_word_select.sv
// Module: chooses between the pseudo-random word and the toggle word and
// computes the next interleave phase and toggle level.
// Assumes it is evaluated only for cycles that emit a word.
module prbs_word_select
    import prbs_pkg::*;
#(
    parameter int W = 16
) (
    input  prbs_mode_e   mode_i,
    input  logic         phase_i,
    input  logic         level_i,
    input  logic [W-1:0] prbs_word_i,
    output logic [W-1:0] word_o,
    output logic         advance_o,
    output logic         phase_o,
    output logic         level_o
);

    logic use_toggle;

    // Decide the word kind from mode and interleave phase.
    always_comb begin
        use_toggle = (mode_i == PAT_TOGGLE) || ((mode_i == PAT_MIX) && phase_i);
        word_o     = use_toggle ? {W{level_i}} : prbs_word_i;
        advance_o  = !use_toggle;
        level_o    = use_toggle ? ~level_i : level_i;
        phase_o    = (mode_i == PAT_MIX) ? ~phase_i : phase_i;
    end

endmodule

// File: rtl/prbs_pattern_gen.sv
// Module: top of the parallel PRBS test pattern generator.
// Holds the captured length, register state, toggle level, interleave phase
// and the registered output word. Reset is synchronous and active low;
// reload dominates enable.
module prbs_pattern_gen
    import prbs_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         reload,
    input  logic [1:0]   len_sel,
    input  logic [1:0]   mode,
    output logic [W-1:0] data_out,
    output logic         data_valid
);

    prbs_len_e          len_q;
    logic [STATE_W-1:0] lfsr_q;
    logic               phase_q;
    logic               level_q;
    logic [W-1:0]       data_q;
    logic               valid_q;

    logic [STATE_W-1:0] lfsr_nxt;
    logic [W-1:0]       prbs_word;
    logic [W-1:0]       sel_word;
    logic               advance;
    logic               phase_nxt;
    logic               level_nxt;

    prbs_lfsr_unroll #(.W(W)) u_unroll (
        .state_i (lfsr_q),
        .len_i   (len_q),
        .state_o (lfsr_nxt),
        .bits_o  (prbs_word)
    );

    prbs_word_select #(.W(W)) u_select (
        .mode_i      (prbs_mode_e'(mode)),
        .phase_i     (phase_q),
        .level_i     (level_q),
        .prbs_word_i (prbs_word),
        .word_o      (sel_word),
        .advance_o   (advance),
        .phase_o     (phase_nxt),
        .level_o     (level_nxt)
    );

    // Sequence state: seed on reset/reload, step on enabled cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || reload) begin
            len_q   <= prbs_len_e'(len_sel);
            lfsr_q  <= len_mask(prbs_len_e'(len_sel));
            phase_q <= 1'b0;
            level_q <= 1'b1;
        end else if (en) begin
            if (advance) lfsr_q <= lfsr_nxt;
            phase_q <= phase_nxt;
            level_q <= level_nxt;
        end
    end

    // Output word and valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (reload) begin
            valid_q <= 1'b0;
        end else if (en) begin
            data_q  <= sel_word;
            valid_q <= 1'b1;
        end else begin
            valid_q <= 1'b0;
        end
    end

    assign data_out   = data_q;
    assign data_valid = valid_q;

endmodule

// File: rtl/prbs_pattern_gen_chk.sv
// Module: property checker bound to the generator top.
// Assumes the reset input is driven low before the first clock edge.
module prbs_pattern_gen_chk
    import prbs_pkg::*;
#(
    parameter int W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               en,
    input logic               reload,
    input logic [1:0]         mode,
    input logic [W-1:0]       data_out,
    input logic               data_valid,
    input logic [STATE_W-1:0] lfsr_state
);

    // R1: reset clears the output.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!data_valid && data_out == '0));

    // R7: an enabled cycle yields a valid word.
    p_valid_on_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !reload) |=> data_valid);

    // R6 / R7: idle or reload cycles give no word and hold the output.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!en || reload) |=> (!data_valid && $stable(data_out)));

    // R9: toggle mode words are uniform.
    p_toggle_uniform_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !reload && mode == 2'd1) |=> (data_out == '0 || data_out == '1));

    // R4: the register never holds all zeros.
    p_state_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .reload     (reload),
    .mode       (mode),
    .data_out   (data_out),
    .data_valid (data_valid),
    .lfsr_state (lfsr_q)
);

// File: tb/prbs_pattern_gen_test.sv
// Bench: bit-serial behavioural model compared with the generator every cycle.
module prbs_pattern_gen_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic         reload = 1'b0;
    logic [1:0]   len_sel = 2'd0;
    logic [1:0]   mode = 2'd0;
    logic [W-1:0] data_out;
    logic         data_valid;

    always #5 clk = ~clk;

    prbs_pattern_gen #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .reload(reload),
        .len_sel(len_sel), .mode(mode),
        .data_out(data_out), .data_valid(data_valid)
    );

    int checks = 0;
    int fails  = 0;

    bit           hist[$];
    int           m_n, m_t;
    bit           m_level, m_phase;
    logic [W-1:0] exp_data = '0;
    bit           exp_valid = 1'b0;
    bit           cap[$];
    bit           capturing = 1'b0;

    function automatic void seed(int code);
        m_n = (code == 0) ? 7 : (code == 1) ? 15 : (code == 2) ? 23 : 31;
        m_t = (code == 0) ? 6 : (code == 1) ? 14 : (code == 2) ? 18 : 28;
        hist.delete();
        repeat (m_n) hist.push_back(1'b1);
        m_level = 1'b1;
        m_phase = 1'b0;
    endfunction

    function automatic bit serial_next();
        bit b;
        b = hist[hist.size() - m_n] ^ hist[hist.size() - m_t];
        hist.push_back(b);
        if (hist.size() > 40) void'(hist.pop_front());
        return b;
    endfunction

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(bit e, bit r, logic [1:0] l, logic [1:0] m, string tag);
        bit is_tog;
        is_tog = 1'b0;
        @(negedge clk);
        en = e; reload = r; len_sel = l; mode = m;
        if (r) begin
            seed(int'(l));
            exp_valid = 1'b0;
        end else if (e) begin
            exp_valid = 1'b1;
            is_tog = (m == 2'd1) || (m == 2'd2 && m_phase);
            if (m == 2'd2) m_phase = ~m_phase;
            if (is_tog) begin
                exp_data = {W{m_level}};
                m_level  = ~m_level;
            end else begin
                for (int i = 0; i < W; i++) exp_data[i] = serial_next();
            end
        end else begin
            exp_valid = 1'b0;
        end
        @(posedge clk);
        #1;
        check(tag, "valid", 64'(data_valid), 64'(exp_valid));
        check(tag, "data", 64'(data_out), 64'(exp_data));
        if (capturing && data_valid && !is_tog)
            for (int i = 0; i < W; i++) cap.push_back(data_out[i]);
    endtask

    task automatic do_reset(logic [1:0] l);
        @(negedge clk);
        rst_n = 1'b0; en = 1'b0; reload = 1'b0; len_sel = l;
        @(posedge clk);
        #1;
        seed(int'(l));
        exp_data = '0;
        exp_valid = 1'b0;
        check("R1", "valid", 64'(data_valid), 64'd0);
        check("R1", "data", 64'(data_out), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R4: period and run-length analysis of captured output bits.
    task automatic analyse(int n);
        int p, mism, zrun, zmax, orun, ones_hits;
        p = (1 << n) - 1;
        mism = 0; zrun = 0; zmax = 0; orun = 0; ones_hits = 0;
        for (int k = 0; k + p < cap.size(); k++)
            if (cap[k] != cap[k + p]) mism++;
        for (int k = 0; k < cap.size(); k++) begin
            zrun = cap[k] ? 0 : zrun + 1;
            orun = cap[k] ? orun + 1 : 0;
            if (zrun > zmax) zmax = zrun;
            if (k >= n - 1 && k < n - 1 + p && orun >= n) ones_hits++;
        end
        check("R4", "period mismatches", 64'(mism), 64'd0);
        check("R4", "zero run below N", 64'(zmax < n), 64'd1);
        check("R4", "one N-ones run per period", 64'(ones_hits), 64'd1);
        check("R4", "enough bits", 64'(cap.size() >= 2 * p), 64'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset(2'd0);
        // R2 / R3: length 7 stream, word boundaries continuous
        repeat (20) step(1, 0, 2'd0, 2'd0, "R3");
        // R7: idle cycles hold output, sequence resumes unbroken
        repeat (3) step(0, 0, 2'd0, 2'd0, "R7");
        repeat (5) step(1, 0, 2'd0, 2'd0, "R7");
        // R9: toggle words
        repeat (6) step(1, 0, 2'd0, 2'd1, "R9");
        step(1, 1, 2'd0, 2'd1, "R6");
        repeat (4) step(1, 0, 2'd0, 2'd1, "R9");
        // R10: interleave with idles mixed in
        step(0, 1, 2'd0, 2'd2, "R6");
        repeat (3) step(1, 0, 2'd0, 2'd2, "R10");
        step(0, 0, 2'd0, 2'd2, "R10");
        repeat (5) step(1, 0, 2'd0, 2'd2, "R10");
        step(0, 0, 2'd0, 2'd2, "R10");
        repeat (4) step(1, 0, 2'd0, 2'd2, "R10");
        // R8: code 3 behaves as pseudo-random
        repeat (5) step(1, 0, 2'd0, 2'd3, "R8");
        // R5: length change without reload ignored
        repeat (8) step(1, 0, 2'd2, 2'd0, "R5");
        // R6: reload with enable high, then length 23
        step(1, 1, 2'd2, 2'd0, "R6");
        repeat (10) step(1, 0, 2'd2, 2'd0, "R2");
        // R2: length 31
        step(0, 1, 2'd3, 2'd0, "R6");
        repeat (10) step(1, 0, 2'd3, 2'd0, "R2");
        // R4: full-period runs at lengths 7 and 15
        step(0, 1, 2'd0, 2'd0, "R6");
        cap.delete();
        capturing = 1'b1;
        repeat (40) step(1, 0, 2'd0, 2'd0, "R4");
        capturing = 1'b0;
        analyse(7);
        step(0, 1, 2'd1, 2'd0, "R6");
        cap.delete();
        capturing = 1'b1;
        repeat (4106) step(1, 0, 2'd1, 2'd0, "R4");
        capturing = 1'b0;
        analyse(15);
        // R1: reset mid-stream, new length captured
        step(1, 0, 2'd1, 2'd2, "R10");
        do_reset(2'd3);
        repeat (6) step(1, 0, 2'd3, 2'd2, "R1");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule